// File: doc/BRIEF.md
# Configurable General-Purpose I/O Port Controller

This block holds the control state for one general-purpose I/O port of up to eight bits. A small register bus reaches three locations: a configuration register, an output data register and a pin-sample location. Each port bit selects its own pin mode from its configuration and data bits: high-impedance input, input with weak pull-up, or push-pull output. The block drives a per-bit output enable, output level and pull-up enable toward the pad ring.

When special functions are enabled, the two top bits of both registers are taken over by power and clock controls. Writing a one to the top data bit raises a single-cycle HALT request, and writing a one to the bit below it raises a single-cycle IDLE request. HALT has priority when both bits are written together. These two data bits are not stored and always read back as zero. The top configuration bit enables a clock start-up delay after HALT, and the bit below it selects the alternate serial clock phase. Neither of those two pins is ever driven.

A second variant forces a number of low pin-sample bits to read as one. In that variant the matching register bits stay readable and writable, serving only as software flags, and their pins are never driven. Pin samples pass through a two-flop synchroniser.

The request sequencer has three states. In `PS_RUN` no request is raised. In `PS_HALT_PULSE` the HALT request is high. In `PS_IDLE_PULSE` the IDLE request is high. The sequencer makes the same transitions from every state:
- T_HALT: a data write with the top bit set moves it to `PS_HALT_PULSE`.
- T_IDLE: a data write with the next bit set and the top bit clear moves it to `PS_IDLE_PULSE`.
- T_DONE: any other cycle returns it to `PS_RUN`.

Top module: `gpio_port_ctl`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted, and in the first cycle after it is released, both registers read zero. Every pin then has `pin_oe`=0, `pin_out`=0 and `pin_pu`=0, and both requests and both special clock controls are low.
- R2: A bit with configuration 0 and data 1 has `pin_pu`=1 and `pin_oe`=0. A bit with configuration 0 and data 0 has `pin_pu`=0 and `pin_oe`=0.
- R3: A bit with configuration 1 has `pin_oe`=1 and `pin_out` equal to its data bit, with `pin_pu`=0. A bit with configuration 0 has `pin_out`=0.
- R4: A write with `bus_we`=1 updates the selected register at the clock edge. `bus_rdata` is combinational on `bus_addr`: address 0 selects the data register and address 1 selects the configuration register.
- R5: A write to address 0 with bit 7 set makes `halt_req` high for exactly the following cycle, unless the next cycle repeats the request. Bit 7 wins over bit 6, and `halt_req` and `idle_req` are never high together.
- R6: A write to address 0 with bit 6 set and bit 7 clear makes `idle_req` high for the following cycle only.
- R7: With special functions enabled, data bits 7 and 6 always read zero at address 0 and never drive or pull up their pins.
- R8: With special functions enabled, configuration bit 6 drives `alt_clk_phase` and configuration bit 7 drives `clk_delay_en`. The pins of bits 7 and 6 always have `pin_oe`=0.
- R9: Address 2 returns the `pin_in` value sampled two clock edges earlier.
- R10: With `FIXED_ONES`=N, the low N bits at address 2 read one whatever `pin_in` is. The low N register bits store and read back normally but leave their pins with `pin_oe`=0, `pin_out`=0 and `pin_pu`=0.
- R11: Address 3 reads zero, and a write to it changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the selected location |
| bus_addr | input | 2 | 0 data, 1 configuration, 2 pin sample, 3 unused |
| bus_wdata | input | PORT_W | Write data |
| bus_rdata | output | PORT_W | Read data for `bus_addr` |
| pin_in | input | PORT_W | Raw pad input levels |
| pin_oe | output | PORT_W | Per-bit output enable |
| pin_out | output | PORT_W | Per-bit output level |
| pin_pu | output | PORT_W | Per-bit weak pull-up enable |
| halt_req | output | 1 | Single-cycle HALT request |
| idle_req | output | 1 | Single-cycle IDLE request |
| alt_clk_phase | output | 1 | Alternate serial clock phase select |
| clk_delay_en | output | 1 | Clock start-up delay enable after HALT |

## Verification
The pin-mode decode is driven with configuration 0x33 against data 0x55. This puts all four configuration/data combinations on neighbouring bits, so a swap of the pull-up and drive terms is caught, and it is followed by a stream of mixed writes.

Request writes of 0x80, 0x40, 0xC0 and two HALT writes back to back separate the priority, the pulse length and the re-arming behaviour.

A changing `pin_in` sequence read at address 2 tells a one-flop or three-flop synchroniser from the correct two-flop one. A second instance with four forced-one bits shows that flag bits store data but leave their pins quiet.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        ADDR_DATA = 2'd0,
        ADDR_CFG  = 2'd1,
        ADDR_PIN  = 2'd2,
        ADDR_NONE = 2'd3
    } port_addr_e;

    typedef enum logic [1:0] {
        PS_RUN        = 2'd0,
        PS_HALT_PULSE = 2'd1,
        PS_IDLE_PULSE = 2'd2
    } pwr_state_e;

endpackage

// File: rtl/port_cfg_regs.sv
module port_cfg_regs #(
    parameter int PORT_W     = 8,
    parameter int SPECIAL_EN = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] cfg_q,
    output logic [PORT_W-1:0] dat_q
);
    import gpio_port_pkg::*;

    // Top two data bits are request strobes, never stored, when special bits are on.
    localparam logic [PORT_W-1:0] DATA_KEEP =
        (SPECIAL_EN != 0) ? {2'b00, {(PORT_W-2){1'b1}}} : {PORT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            dat_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_DATA) dat_q <= bus_wdata & DATA_KEEP;
            if (bus_addr == ADDR_CFG)  cfg_q <= bus_wdata;
        end
    end

endmodule

// File: rtl/port_pin_sync.sv
module port_pin_sync #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_sync
);
    logic [PORT_W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1   <= '0;
            pin_sync <= '0;
        end else begin
            stage1   <= pin_in;
            pin_sync <= stage1;
        end
    end

endmodule

// File: rtl/port_pwr_fsm.sv
module port_pwr_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_wr,
    input  logic idle_wr,
    output logic halt_req,
    output logic idle_req
);
    import gpio_port_pkg::*;

    pwr_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_RUN;
        else        state <= nxt;
    end

    // T_HALT has priority over T_IDLE; otherwise T_DONE back to PS_RUN.
    always_comb begin
        nxt = PS_RUN;
        unique case (state)
            PS_RUN: begin
                if (halt_wr)      nxt = PS_HALT_PULSE;
                else if (idle_wr) nxt = PS_IDLE_PULSE;
                else              nxt = PS_RUN;
            end
            PS_HALT_PULSE: begin
                if (halt_wr)      nxt = PS_HALT_PULSE;
                else if (idle_wr) nxt = PS_IDLE_PULSE;
                else              nxt = PS_RUN;
            end
            PS_IDLE_PULSE: begin
                if (halt_wr)      nxt = PS_HALT_PULSE;
                else if (idle_wr) nxt = PS_IDLE_PULSE;
                else              nxt = PS_RUN;
            end
            default: nxt = PS_RUN;
        endcase
    end

    always_comb begin
        halt_req = 1'b0;
        idle_req = 1'b0;
        unique case (state)
            PS_RUN:        ;
            PS_HALT_PULSE: halt_req = 1'b1;
            PS_IDLE_PULSE: idle_req = 1'b1;
            default:       ;
        endcase
    end

endmodule

// File: rtl/port_pin_drive.sv
module port_pin_drive #(
    parameter int PORT_W     = 8,
    parameter int SPECIAL_EN = 1,
    parameter int FIXED_ONES = 0
) (
    input  logic [PORT_W-1:0] cfg_q,
    input  logic [PORT_W-1:0] dat_q,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_pu
);
    logic [PORT_W-1:0] drive_mask;

    // Special-function bits and flag-only bits never reach a pad.
    for (genvar i = 0; i < PORT_W; i++) begin : g_mask
        localparam bit IS_SPECIAL = (SPECIAL_EN != 0) && (i >= PORT_W - 2);
        localparam bit IS_FLAG    = (i < FIXED_ONES);
        assign drive_mask[i] = !(IS_SPECIAL || IS_FLAG);
    end

    assign pin_oe  = cfg_q & drive_mask;
    assign pin_out = cfg_q & dat_q & drive_mask;
    assign pin_pu  = ~cfg_q & dat_q & drive_mask;

endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl #(
    parameter int PORT_W     = 8,
    parameter int SPECIAL_EN = 1,
    parameter int FIXED_ONES = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_pu,
    output logic              halt_req,
    output logic              idle_req,
    output logic              alt_clk_phase,
    output logic              clk_delay_en
);
    import gpio_port_pkg::*;

    localparam int HI_BIT = PORT_W - 1;
    localparam int LO_SPC = PORT_W - 2;

    logic [PORT_W-1:0] cfg_q, dat_q, pin_sync, ones_mask;

    port_cfg_regs #(.PORT_W(PORT_W), .SPECIAL_EN(SPECIAL_EN)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cfg_q(cfg_q), .dat_q(dat_q)
    );

    port_pin_sync #(.PORT_W(PORT_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_sync(pin_sync)
    );

    port_pin_drive #(.PORT_W(PORT_W), .SPECIAL_EN(SPECIAL_EN),
                     .FIXED_ONES(FIXED_ONES)) u_drive (
        .cfg_q(cfg_q), .dat_q(dat_q),
        .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu)
    );

    for (genvar i = 0; i < PORT_W; i++) begin : g_ones
        assign ones_mask[i] = (i < FIXED_ONES);
    end

    if (SPECIAL_EN != 0) begin : g_special
        logic halt_wr, idle_wr;
        assign halt_wr = bus_we && (bus_addr == ADDR_DATA) && bus_wdata[HI_BIT];
        assign idle_wr = bus_we && (bus_addr == ADDR_DATA) && bus_wdata[LO_SPC];

        port_pwr_fsm u_fsm (
            .clk(clk), .rst_n(rst_n), .halt_wr(halt_wr), .idle_wr(idle_wr),
            .halt_req(halt_req), .idle_req(idle_req)
        );

        assign alt_clk_phase = cfg_q[LO_SPC];
        assign clk_delay_en  = cfg_q[HI_BIT];
    end else begin : g_plain
        assign halt_req      = 1'b0;
        assign idle_req      = 1'b0;
        assign alt_clk_phase = 1'b0;
        assign clk_delay_en  = 1'b0;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_DATA: bus_rdata = dat_q;
            ADDR_CFG:  bus_rdata = cfg_q;
            ADDR_PIN:  bus_rdata = pin_sync | ones_mask;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/port_ctl_checker.sv
module port_ctl_checker #(
    parameter int PORT_W     = 8,
    parameter int SPECIAL_EN = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [1:0]        bus_addr,
    input logic [PORT_W-1:0] bus_wdata,
    input logic [PORT_W-1:0] bus_rdata,
    input logic [PORT_W-1:0] pin_oe,
    input logic [PORT_W-1:0] pin_out,
    input logic [PORT_W-1:0] pin_pu,
    input logic              halt_req,
    input logic              idle_req
);
    localparam bit SPC = (SPECIAL_EN != 0);

    a_r5_halt_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> $past(bus_we && bus_addr == 2'd0 && bus_wdata[PORT_W-1]));

    a_r6_idle_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        idle_req |-> $past(bus_we && bus_addr == 2'd0 && bus_wdata[PORT_W-2]
                           && !bus_wdata[PORT_W-1]));

    a_r5_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        !(halt_req && idle_req));

    a_r2_pullup_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    a_r3_level_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);

    a_r7_request_bits_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (SPC && bus_addr == 2'd0) |-> bus_rdata[PORT_W-1 -: 2] == 2'b00);

    a_r8_special_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        SPC |-> (pin_oe[PORT_W-1 -: 2] == 2'b00 && pin_pu[PORT_W-1 -: 2] == 2'b00));

endmodule

bind gpio_port_ctl port_ctl_checker #(.PORT_W(PORT_W), .SPECIAL_EN(SPECIAL_EN)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_oe(pin_oe),
    .pin_out(pin_out), .pin_pu(pin_pu), .halt_req(halt_req), .idle_req(idle_req)
);

// File: tb/sim_gpio_port_ctl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctl;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0, we = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wd = 8'h00, pin_in = 8'h00;
    logic [7:0] rdata, oe, pout, pu;
    logic       halt, idle, alt, dly;

    gpio_port_ctl #(.PORT_W(8), .SPECIAL_EN(1), .FIXED_ONES(0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wd),
        .bus_rdata(rdata), .pin_in(pin_in), .pin_oe(oe), .pin_out(pout),
        .pin_pu(pu), .halt_req(halt), .idle_req(idle),
        .alt_clk_phase(alt), .clk_delay_en(dly)
    );

    logic       b_we = 1'b0;
    logic [1:0] b_addr = 2'd0;
    logic [7:0] b_wd = 8'h00, b_pin = 8'h00;
    logic [7:0] b_rdata, b_oe, b_out, b_pu;
    logic       b_halt, b_idle, b_alt, b_dly;

    gpio_port_ctl #(.PORT_W(8), .SPECIAL_EN(0), .FIXED_ONES(4)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_we(b_we), .bus_addr(b_addr), .bus_wdata(b_wd),
        .bus_rdata(b_rdata), .pin_in(b_pin), .pin_oe(b_oe), .pin_out(b_out),
        .pin_pu(b_pu), .halt_req(b_halt), .idle_req(b_idle),
        .alt_clk_phase(b_alt), .clk_delay_en(b_dly)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Behavioural reference state
    logic [7:0] m_cfg = 8'h00, m_dat = 8'h00;
    logic [7:0] hist[$];
    bit m_halt = 1'b0, m_idle = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cfg = 8'h00; m_dat = 8'h00; m_halt = 0; m_idle = 0;
            hist.delete(); hist.push_back(8'h00); hist.push_back(8'h00);
        end else begin
            m_halt = we && addr == 2'd0 && wd[7];
            m_idle = we && addr == 2'd0 && wd[6] && !wd[7];
            if (we && addr == 2'd0) m_dat = wd & 8'h3F;
            if (we && addr == 2'd1) m_cfg = wd;
            hist.push_back(pin_in);
            void'(hist.pop_front());
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            logic [7:0] exp_rd;
            string tr;
            case (addr)
                2'd0: begin exp_rd = m_dat; tr = "R4"; end
                2'd1: begin exp_rd = m_cfg; tr = "R4"; end
                2'd2: begin exp_rd = (hist.size() == 2) ? hist[0] : 8'h00; tr = "R9"; end
                default: begin exp_rd = 8'h00; tr = "R11"; end
            endcase
            if (!rst_n) tr = "R1";
            chk(tr, rdata, exp_rd);
            chk(rst_n ? "R3 oe" : "R1 oe", oe, m_cfg & 8'h3F);
            chk(rst_n ? "R3 out" : "R1 out", pout, m_cfg & m_dat & 8'h3F);
            chk(rst_n ? "R2 pu" : "R1 pu", pu, ~m_cfg & m_dat & 8'h3F);
            chk("R5 halt", halt, m_halt);
            chk("R6 idle", idle, m_idle);
            chk("R8 alt", alt, m_cfg[6]);
            chk("R8 dly", dly, m_cfg[7]);
            if (addr == 2'd0) chk("R7 top bits", rdata[7:6], 2'b00);
        end
    end

    task automatic step(input logic w, input logic [1:0] a, input logic [7:0] d,
                        input logic [7:0] p);
        @(posedge clk); #5;
        we = w; addr = a; wd = d; pin_in = p;
    endtask

    task automatic bstep(input logic w, input logic [1:0] a, input logic [7:0] d,
                         input logic [7:0] p);
        @(posedge clk); #5;
        b_we = w; b_addr = a; b_wd = d; b_pin = p;
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step(0, 2'd0, 8'h00, 8'h00);
        @(posedge clk); #5; rst_n = 1'b1;
        // R1: first cycle after release still reads reset values
        step(0, 2'd1, 8'h00, 8'h00);
        // R2/R3: all four cfg/data combinations
        step(1, 2'd1, 8'h33, 8'h00);
        step(1, 2'd0, 8'h55, 8'h00);
        step(0, 2'd0, 8'h00, 8'h00);
        step(0, 2'd1, 8'h00, 8'h00);
        // R5/R6/R7 requests
        step(1, 2'd0, 8'hFF, 8'h00);
        step(0, 2'd0, 8'h00, 8'h00);
        step(1, 2'd0, 8'h40, 8'h00);
        step(0, 2'd0, 8'h00, 8'h00);
        step(1, 2'd0, 8'hC0, 8'h00);
        step(0, 2'd0, 8'h00, 8'h00);
        step(1, 2'd0, 8'h80, 8'h00);
        step(1, 2'd0, 8'h81, 8'h00);
        step(1, 2'd0, 8'h4A, 8'h00);
        step(0, 2'd0, 8'h00, 8'h00);
        // R8 special clock controls
        step(1, 2'd1, 8'hC0, 8'h00);
        step(1, 2'd0, 8'h3F, 8'h00);
        step(1, 2'd1, 8'h7F, 8'h00);
        step(1, 2'd1, 8'hBF, 8'h00);
        // R11 unused address
        step(1, 2'd3, 8'hAA, 8'h00);
        step(0, 2'd0, 8'h00, 8'h00);
        step(0, 2'd1, 8'h00, 8'h00);
        step(0, 2'd3, 8'h00, 8'h00);
        // R9 pin sampling latency
        step(0, 2'd2, 8'h00, 8'hA5);
        step(0, 2'd2, 8'h00, 8'h5A);
        step(0, 2'd2, 8'h00, 8'hFF);
        step(0, 2'd2, 8'h00, 8'h00);
        step(0, 2'd2, 8'h00, 8'h3C);
        step(0, 2'd2, 8'h00, 8'h3C);
        step(0, 2'd2, 8'h00, 8'hC3);
        step(0, 2'd2, 8'h00, 8'hC3);
        // mixed traffic
        for (int i = 0; i < 200; i++) begin
            logic [7:0] v;
            v = 8'(i * 37 + 11);
            step(v[0] ^ v[5], 2'(v[3:2] + i[1:0]), 8'(v * 8'd13), 8'(v ^ 8'h96));
        end
        step(0, 2'd2, 8'h00, 8'h00);
        step(0, 2'd2, 8'h00, 8'h00);

        // R10: second instance with four flag-only bits
        bstep(1, 2'd1, 8'hFF, 8'h00);
        bstep(1, 2'd0, 8'h5A, 8'h00);
        bstep(0, 2'd2, 8'h00, 8'h00);
        bstep(0, 2'd2, 8'h00, 8'h00);
        @(negedge clk); #1;
        chk("R10 pin read low ones", b_rdata, 8'h0F);
        chk("R10 flag bits oe", b_oe, 8'hF0);
        chk("R10 flag bits out", b_out, 8'h50);
        chk("R10 flag bits pu", b_pu, 8'h00);
        bstep(0, 2'd0, 8'h00, 8'h00);
        @(negedge clk); #1;
        chk("R10 flag bits stored", b_rdata, 8'h5A);
        bstep(1, 2'd1, 8'h00, 8'h00);
        bstep(0, 2'd2, 8'h00, 8'hF0);
        bstep(0, 2'd2, 8'h00, 8'hF0);
        bstep(0, 2'd2, 8'h00, 8'hF0);
        @(negedge clk); #1;
        chk("R10 pin read with high pins", b_rdata, 8'hFF);
        chk("R10 pull-up only on real pins", b_pu, 8'h50);
        chk("R10 no requests", {b_halt, b_idle, b_alt, b_dly}, 4'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule